// File: doc/BRIEF.md
# Bus-Attached Serial Port with Line-Status Subset

This block connects a single-character serial transmitter and receiver to a 32-bit Wishbone slave port. Software sees three byte-wide registers: a write-only transmit holding register and a read-only receive holding register, which share byte address 0, and a read-only line-status register at byte address 5. The register positions and status bits match the classic 16550 layout, so a polled boot monitor written for that UART can run without changes. The block has no FIFOs. Each direction holds exactly one character.

The bus is big-endian. Byte address 0 is lane 3 of word 0 (`wb_sel_i[3]`, `wb_dat_*[31:23+1]`). Byte address 5 is lane 2 of word 1 (`wb_dat_o[23:16]`). Every strobed bus cycle gets a one-cycle acknowledge on the following clock, with no wait states. The serial format is fixed: 8 data bits, least significant first, no parity, one stop bit. The bit time is set by a parameter.

Top module: `serial_port_wb`

## Requirements
- R1: After reset the serial output is high, the acknowledge is low, and the status register reads receive-ready 0 and transmit-empty 1.
- R2: A cycle with `wb_cyc_i` and `wb_stb_i` high while acknowledge is low is accepted. Acknowledge is high for exactly the one following clock cycle, and read data is valid in that cycle.
- R3: An accepted write to word 0 with `wb_sel_i[3]` high, while the transmitter is empty, sends `wb_dat_i[31:24]` as a frame of CLKS_PER_BIT cycles per bit: one low start bit, 8 data bits LSB first, then one high stop bit. The frame starts in the cycle after acceptance. The line is high whenever no frame is being sent.
- R4: Status bit 5 (transmit empty) is 0 from the cycle after a byte is loaded. It returns to 1 exactly 10×CLKS_PER_BIT cycles after the load, when the stop bit has finished.
- R5: A transmit write accepted while status bit 5 is 0 is ignored, and the frame in progress continues unchanged.
- R6: A write to word 0 with `wb_sel_i[3]` low, or any write to word 1, starts no frame and changes no status bit.
- R7: When the receiver samples a high stop bit, the received byte becomes readable at byte address 0 (`wb_dat_o[31:24]`) and status bit 0 (data ready) becomes 1.
- R8: An accepted read of word 0 with `wb_sel_i[3]` high clears status bit 0. A read of word 0 with `wb_sel_i[3]` low returns the byte but leaves bit 0 set.
- R9: A read of word 1 returns the status byte in `wb_dat_o[23:16]`. Only bit 0 (data ready) and bit 5 (transmit empty) can be 1, and every other bit of `wb_dat_o` is 0.
- R10: A low pulse on the serial input shorter than half a bit time is rejected as a false start, and no character is received.
- R11: A frame whose stop bit samples low is discarded. Status bit 0 and the held byte stay unchanged.
- R12: A character that completes while status bit 0 is already 1 replaces the held byte, and bit 0 stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADR_W | Byte address; bits above the lane bits select the word |
| wb_sel_i | input | DAT_W/8 | Byte-lane selects, lane 3 = byte address 0 |
| wb_dat_i | input | DAT_W | Write data |
| wb_dat_o | output | DAT_W | Read data, valid while acknowledge is high |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| txd_o | output | 1 | Serial transmit line, idles high |
| rxd_i | input | 1 | Serial receive line |

## Verification
A wrong transmit state shows on `txd_o` within one bit time, and a wrong bit count shows within one frame. Such a fault also moves the rising edge of status bit 5, which a status read exposes to the exact cycle. A wrong receive-ready state shows at the next status read, and a wrong receive shift register shows as a wrong byte when data is read. A stuck or doubled acknowledge shows on the very next clock.

// File: rtl/sp_wb_pkg.sv
package sp_wb_pkg;

  localparam int CHAR_BITS    = 8;
  localparam int FRAME_BITS   = CHAR_BITS + 2;
  localparam int ST_READY_BIT = 0;
  localparam int ST_EMPTY_BIT = 5;
  localparam int DATA_OFFSET  = 0;
  localparam int STAT_OFFSET  = 5;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  // Line-status byte: only ready and empty are ever set.
  function automatic logic [7:0] status_byte(input logic ready, input logic empty);
    logic [7:0] s;
    s = '0;
    s[ST_READY_BIT] = ready;
    s[ST_EMPTY_BIT] = empty;
    return s;
  endfunction

  // Shift-out image of a character: start at bit 0, stop at the top.
  function automatic logic [FRAME_BITS-1:0] frame_of(input logic [CHAR_BITS-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  // Big-endian lane of a byte offset within a bus word.
  function automatic int lane_of(input int offset, input int lanes);
    return lanes - 1 - (offset % lanes);
  endfunction

  function automatic int word_of(input int offset, input int lanes);
    return offset / lanes;
  endfunction

endpackage

// File: rtl/sp_tx.sv
module sp_tx
  import sp_wb_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [CHAR_BITS-1:0] din,
  output logic                 txd,
  output logic                 idle
);

  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);

  logic                  busy;
  logic [CW-1:0]         cnt;
  logic [BW-1:0]         bitn;
  logic [FRAME_BITS-1:0] shreg;
  logic                  bit_end;

  assign bit_end = (cnt == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '1;
    end else if (!busy) begin
      if (load) begin
        shreg <= frame_of(din);
        busy  <= 1'b1;
        cnt   <= '0;
        bitn  <= '0;
      end
    end else if (bit_end) begin
      cnt   <= '0;
      shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
      if (bitn == BW'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
      end else begin
        bitn <= bitn + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign txd  = busy ? shreg[0] : 1'b1;
  assign idle = !busy;

endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_wb_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxd,
  output logic                 done,
  output logic [CHAR_BITS-1:0] data
);

  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int BW   = $clog2(CHAR_BITS + 1);

  rx_state_t            st;
  logic [1:0]           sync;
  logic                 line;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [CHAR_BITS-1:0] shreg;
  logic                 bit_end;

  assign line    = sync[1];
  assign bit_end = (cnt == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync  <= 2'b11;
      st    <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      done  <= 1'b0;
      data  <= '0;
    end else begin
      sync <= {sync[0], rxd};
      done <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!line) st <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt   <= '0;
            shreg <= {line, shreg[CHAR_BITS-1:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == BW'(CHAR_BITS - 1)) st <= RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt <= '0;
            st  <= RX_IDLE;
            if (line) begin
              done <= 1'b1;
              data <= shreg;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_port_wb.sv
module serial_port_wb
  import sp_wb_pkg::*;
#(
  parameter int ADR_W        = 8,
  parameter int DAT_W        = 32,
  parameter int CLKS_PER_BIT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  input  logic               wb_we_i,
  input  logic [ADR_W-1:0]   wb_adr_i,
  input  logic [DAT_W/8-1:0] wb_sel_i,
  input  logic [DAT_W-1:0]   wb_dat_i,
  output logic [DAT_W-1:0]   wb_dat_o,
  output logic               wb_ack_o,
  output logic               txd_o,
  input  logic               rxd_i
);

  localparam int LANES     = DAT_W / 8;
  localparam int ADR_LSB   = $clog2(LANES);
  localparam int WORD_W    = ADR_W - ADR_LSB;
  localparam int DATA_LANE = lane_of(DATA_OFFSET, LANES);
  localparam int STAT_LANE = lane_of(STAT_OFFSET, LANES);
  localparam int DATA_WORD = word_of(DATA_OFFSET, LANES);
  localparam int STAT_WORD = word_of(STAT_OFFSET, LANES);

  // Named internal events, also observed by the bound checker.
  logic                 accept;
  logic                 at_data;
  logic                 at_stat;
  logic                 tx_wr;
  logic                 tx_load;
  logic                 rx_rd;
  logic                 stat_rd;
  logic                 tx_empty;
  logic                 rx_done;
  logic                 rx_full;
  logic [CHAR_BITS-1:0] rx_byte;
  logic [WORD_W-1:0]    word;

  assign word    = wb_adr_i[ADR_W-1:ADR_LSB];
  assign accept  = wb_cyc_i && wb_stb_i && !wb_ack_o;
  assign at_data = (word == WORD_W'(DATA_WORD));
  assign at_stat = (word == WORD_W'(STAT_WORD));
  assign tx_wr   = accept && wb_we_i && at_data && wb_sel_i[DATA_LANE];
  assign tx_load = tx_wr && tx_empty;
  assign rx_rd   = accept && !wb_we_i && at_data && wb_sel_i[DATA_LANE];
  assign stat_rd = accept && !wb_we_i && at_stat;

  sp_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .load (tx_load),
    .din  (wb_dat_i[DATA_LANE*8 +: 8]),
    .txd  (txd_o),
    .idle (tx_empty)
  );

  sp_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk  (clk),
    .rst  (rst),
    .rxd  (rxd_i),
    .done (rx_done),
    .data (rx_byte)
  );

  // Data-ready flag: a finished character wins over a clearing read.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full <= 1'b0;
    end else if (rx_done) begin
      rx_full <= 1'b1;
    end else if (rx_rd) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= accept;
      wb_dat_o <= '0;
      if (accept && !wb_we_i) begin
        if (at_data) wb_dat_o[DATA_LANE*8 +: 8] <= rx_byte;
        if (at_stat) wb_dat_o[STAT_LANE*8 +: 8] <= status_byte(rx_full, tx_empty);
      end
    end
  end

endmodule

// File: rtl/sp_wb_chk.sv
module sp_wb_chk
  import sp_wb_pkg::*;
#(
  parameter int DAT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc,
  input logic             stb,
  input logic             ack,
  input logic             txd,
  input logic             tx_empty,
  input logic             tx_load,
  input logic             tx_wr,
  input logic             rx_done,
  input logic             rx_full,
  input logic             rx_rd,
  input logic             stat_rd,
  input logic [DAT_W-1:0] dat_o
);

  localparam int STAT_LANE = lane_of(STAT_OFFSET, DAT_W / 8);
  localparam logic [DAT_W-1:0] STAT_MASK =
    DAT_W'({status_byte(1'b1, 1'b1)}) << (STAT_LANE * 8);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R2

  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(cyc && stb)); // R2

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd); // R3

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> (!txd && !tx_empty)); // R4

  AST_BUSY_WRITE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && !tx_empty && !$rose(tx_empty)) |=> $stable(txd) || !tx_empty); // R5

  AST_RX_SET: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_full); // R7

  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !rx_done) |=> !rx_full); // R8

  AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> ((dat_o & ~STAT_MASK) == '0)); // R9

endmodule

bind serial_port_wb sp_wb_chk #(.DAT_W(DAT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cyc      (wb_cyc_i),
  .stb      (wb_stb_i),
  .ack      (wb_ack_o),
  .txd      (txd_o),
  .tx_empty (tx_empty),
  .tx_load  (tx_load),
  .tx_wr    (tx_wr),
  .rx_done  (rx_done),
  .rx_full  (rx_full),
  .rx_rd    (rx_rd),
  .stat_rd  (stat_rd),
  .dat_o    (wb_dat_o)
);

// File: tb/test_serial_port_wb.sv
`timescale 1ns/1ps
module test_serial_port_wb;

  localparam int CPB   = 16;
  localparam int FRAME = 10 * CPB;

  logic        clk = 1'b0;
  logic        rst;
  logic        cyc, stb, we;
  logic [7:0]  adr;
  logic [3:0]  sel;
  logic [31:0] dat_i;
  logic [31:0] dat_o;
  logic        ack;
  logic        txd;
  logic        rxd;

  always #2.5 clk = ~clk;

  serial_port_wb #(.ADR_W(8), .DAT_W(32), .CLKS_PER_BIT(CPB)) i_serial_port_wb (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(dat_i), .wb_dat_o(dat_o),
    .wb_ack_o(ack), .txd_o(txd), .rxd_i(rxd)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  int    wd     = 0;
  bit    finished = 1'b0;
  string tx_req = "R3";

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Status word as software expects it: byte 5 -> bits 23:16, ready=bit0, empty=bit5.
  function automatic logic [31:0] exp_status(input bit ready, input bit empty);
    logic [31:0] v;
    v = 32'h0;
    if (ready) v = v + 32'h0001_0000;
    if (empty) v = v + 32'h0020_0000;
    return v;
  endfunction

  // Behavioural reference: acknowledge and transmit line, advanced each edge.
  bit          m_ack;
  bit          m_busy;
  int          m_cnt;
  logic [9:0]  m_bits;
  bit          m_empty_cap;
  bit          m_acc;
  bit          m_was_idle;

  always @(posedge clk) begin
    if (rst) begin
      m_ack  = 1'b0;
      m_busy = 1'b0;
      m_cnt  = 0;
    end else begin
      m_acc      = cyc && stb && !m_ack;
      m_was_idle = !m_busy;
      if (m_acc && !we) m_empty_cap = m_was_idle;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == FRAME) m_busy = 1'b0;
      end
      if (m_acc && we && adr[7:2] == 6'd0 && sel[3] && m_was_idle) begin
        m_bits = {1'b1, dat_i[31:24], 1'b0};
        m_busy = 1'b1;
        m_cnt  = 0;
      end
      m_ack = m_acc;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(txd == (m_busy ? m_bits[m_cnt / CPB] : 1'b1), tx_req,
            32'(txd), 32'(m_busy ? m_bits[m_cnt / CPB] : 1'b1));
      check(ack == m_ack, "R2", 32'(ack), 32'(m_ack));
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; sel = s; dat_i = d;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [3:0] s, output logic [31:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a; sel = s;
    @(negedge clk);
    d = dat_o;
    cyc = 1'b0; stb = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] c, input bit stop);
    logic [9:0] f;
    f = {stop, c, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = f[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected<150000 cycles", wd);
      report();
    end
  end

  initial begin
    logic [31:0] d;
    int guard;
    rst = 1'b1; cyc = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; sel = '0;
    dat_i = '0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    check(txd == 1'b1, "R1", 32'(txd), 32'd1);
    check(ack == 1'b0, "R1", 32'(ack), 32'd0);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(0, 1), "R1", d, exp_status(0, 1));
    bus_read(8'h04, 4'b0100, d);
    check(d == exp_status(0, 1), "R9", d, exp_status(0, 1));

    // R3/R4: one frame, with status polled every cycle across the end.
    tx_req = "R3";
    bus_write(8'h00, 4'b1000, 32'hA5_12_34_56);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(0, 0), "R4", d, exp_status(0, 0));
    guard = 0;
    do begin
      bus_read(8'h04, 4'hF, d);
      check(d == exp_status(0, m_empty_cap), "R4", d, exp_status(0, m_empty_cap));
      guard++;
    end while (!m_empty_cap && guard < 400);
    check(d == exp_status(0, 1), "R4", d, exp_status(0, 1));

    // R5: second write during a frame is dropped.
    tx_req = "R5";
    bus_write(8'h00, 4'b1000, 32'h3C_00_00_00);
    repeat (3 * CPB) @(negedge clk);
    bus_write(8'h00, 4'b1000, 32'hFF_00_00_00);
    while (m_busy) @(negedge clk);
    repeat (CPB) @(negedge clk);

    // R6: writes off the data lane or to the status word start nothing.
    tx_req = "R6";
    bus_write(8'h00, 4'b0111, 32'h00_FF_FF_FF);
    bus_write(8'h04, 4'b1111, 32'h55_FF_FF_FF);
    repeat (2 * CPB) @(negedge clk);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(0, 1), "R6", d, exp_status(0, 1));
    tx_req = "R3";

    // R7/R8: receive, non-clearing read, clearing read.
    send_char(8'h5A, 1'b1);
    repeat (2 * CPB) @(negedge clk);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(1, 1), "R7", d, exp_status(1, 1));
    bus_read(8'h00, 4'b0111, d);
    check(d == 32'h5A00_0000, "R7", d, 32'h5A00_0000);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(1, 1), "R8", d, exp_status(1, 1));
    bus_read(8'h00, 4'b1000, d);
    check(d == 32'h5A00_0000, "R8", d, 32'h5A00_0000);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(0, 1), "R8", d, exp_status(0, 1));

    // R10: short low glitch.
    rxd = 1'b0;
    repeat (CPB / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * CPB) @(negedge clk);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(0, 1), "R10", d, exp_status(0, 1));

    // R11: bad stop bit.
    send_char(8'h11, 1'b0);
    repeat (3 * CPB) @(negedge clk);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(0, 1), "R11", d, exp_status(0, 1));
    bus_read(8'h00, 4'b0111, d);
    check(d == 32'h5A00_0000, "R11", d, 32'h5A00_0000);

    // R12: overrun replaces the held byte.
    send_char(8'h81, 1'b1);
    send_char(8'h7E, 1'b1);
    repeat (2 * CPB) @(negedge clk);
    bus_read(8'h04, 4'hF, d);
    check(d == exp_status(1, 1), "R12", d, exp_status(1, 1));
    bus_read(8'h00, 4'b1000, d);
    check(d == 32'h7E00_0000, "R12", d, 32'h7E00_0000);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    report();
  end

endmodule